// File: doc/BRIEF.md
# Daisy-Chain ADC Readout Host Controller

This block sits on the host side of two cascaded six-channel sampling converters. Both converters share one conversion-start line. The far converter shifts its serial output into the near converter, and the near converter drives the host. On a start request the controller does four things in order:

1. It pulses conversion-start.
2. It waits for the converters' busy signal to rise and then fall.
3. It opens one chip-select frame and toggles the serial clock through it.
4. It collects the serial bits on two or three data lanes and files them into a twelve-word result array.

When the frame closes, a one-cycle done strobe tells the consumer that all twelve words are current.

The lane count is a mode input, latched when a start request is accepted. It sets two things: how long the frame is, and which converter channel each 16-bit slot on each lane belongs to. The near converter's words always come out in the first half of every lane's stream. The far converter's words, relayed through the near one, come out in the second half.

Top module: `daisy_readout_ctrl`

## Requirements
- R1: While reset is held and after it is released, conversion-start is low, chip-select is high, serial clock is high, done is low and every result word is zero.
- R2: A start request seen while the controller is idle drives conversion-start high for exactly CONV_CYC cycles (default 4). Conversion-start then returns low and stays low for the rest of the conversion and the whole frame.
- R3: Chip-select falls only after busy has been seen high and then seen low, and never while busy is high.
- R4: The serial clock idles high and stays high outside a frame. Inside a frame it starts with a high phase of HALF_DIV cycles (default 2), then alternates low and high phases of HALF_DIV cycles each. A data bit is sampled at each high-to-low transition. The first bit must already be present when chip-select falls.
- R5: In two-lane mode (lane select 0) chip-select stays low for exactly 96 sampled bits, that is 96·2·HALF_DIV cycles.
- R6: In three-lane mode (lane select 1) chip-select stays low for exactly 64 sampled bits, that is 64·2·HALF_DIV cycles.
- R7: In two-lane mode, each lane carries 16-bit words MSB first. Lane 0 (input bit 0) carries channels 1, 2, 5 of the near converter, then channels 1, 2, 5 of the far converter. Lane 1 (bit 1) carries channels 3, 4, 6 in the same near-then-far order. Lane 2 (bit 2) is ignored.
- R8: In three-lane mode each lane carries two near words and then two far words, MSB first: lane 0 carries channels 1 and 2, lane 1 carries channels 3 and 4, and lane 2 carries channels 5 and 6.
- R9: Channel c (1 to 6) of converter d (near 0, far 1) is stored in result bits [16·(6·d + c − 1) +: 16].
- R10: Done is high for exactly one cycle, the first cycle in which chip-select is high again after a frame, and the twelve words are final in that cycle.
- R11: A start request arriving while a conversion, wait or frame is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion and readout |
| busy_i | input | 1 | Converters' busy indication, high during conversion |
| lanes3_i | input | 1 | Lane count select: 0 two lanes, 1 three lanes |
| lane_din_i | input | 3 | Serial data lanes from the near converter |
| convst_o | output | 1 | Conversion-start to both converters |
| cs_n_o | output | 1 | Active-low chip-select framing the transfer |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | 192 | Twelve 16-bit results, near channels 1-6 then far channels 1-6 |
| done_o | output | 1 | One-cycle strobe when the result array is complete |

## Verification
The assertions assume the converters behave as the host expects. Busy rises after conversion-start and falls only after conversion-start has returned low. The data lanes change only right after chip-select falls or right after a serial-clock rising edge. The bench's converter model holds to both: it raises busy one cycle after the start pulse and keeps it high for longer than the conversion-start width. It also updates the lanes only on those two events, always half a system clock away from the controller's sampling edge. Start requests placed during the conversion and in the middle of a frame test the ignore rule without breaking these assumptions.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    localparam int WORD_W     = 16;
    localparam int CH_PER_DEV = 6;
    localparam int N_DEV      = 2;
    localparam int N_LANE     = 3;
    localparam int N_WORDS    = CH_PER_DEV * N_DEV;
    localparam int BITS_2L    = WORD_W * N_WORDS / 2;
    localparam int BITS_3L    = WORD_W * N_WORDS / 3;
    localparam int SLOT_W     = $clog2(N_WORDS);
    localparam int BIT_CNT_W  = $clog2(BITS_2L + 1);
    localparam int WIDX_W     = BIT_CNT_W - $clog2(WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_XFER,
        ST_DONE
    } rdo_state_e;
endpackage

// File: rtl/rdo_slot_map.sv
module rdo_slot_map
    import rdo_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic                three_lane_i,
    input  logic [WIDX_W-1:0]   word_idx_i,
    output logic [SLOT_W-1:0]   slot_o,
    output logic                valid_o
);
    int per;
    int dev;
    int k;
    int ch;

    always_comb begin
        per     = three_lane_i ? 2 : 3;
        dev     = (int'(word_idx_i) >= per) ? 1 : 0;
        k       = int'(word_idx_i) - dev * per;
        valid_o = 1'b1;
        ch      = 0;
        if (three_lane_i) begin
            ch = LANE * 2 + k;
        end else begin
            case (LANE)
                0:       ch = (k == 2) ? 4 : k;
                1:       ch = (k == 2) ? 5 : k + 2;
                default: valid_o = 1'b0;
            endcase
        end
        if (dev >= N_DEV) valid_o = 1'b0;
        slot_o = SLOT_W'(dev * CH_PER_DEV + ch);
    end
endmodule

// File: rtl/rdo_lane_shift.sv
module rdo_lane_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);
    logic [W-2:0] sh_d, sh_q;

    assign word_o = {sh_q, din_i};

    always_comb begin
        sh_d = sh_q;
        if (en_i) sh_d = word_o[W-2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/daisy_readout_ctrl.sv
module daisy_readout_ctrl
    import rdo_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CONV_CYC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        busy_i,
    input  logic                        lanes3_i,
    input  logic [N_LANE-1:0]           lane_din_i,
    output logic                        convst_o,
    output logic                        cs_n_o,
    output logic                        sclk_o,
    output logic [N_WORDS*WORD_W-1:0]   result_o,
    output logic                        done_o
);
    localparam int DIV_W  = $clog2(HALF_DIV + 1);
    localparam int CONV_W = $clog2(CONV_CYC + 1);

    typedef struct packed {
        rdo_state_e                           state;
        logic [DIV_W-1:0]                     div;
        logic [CONV_W-1:0]                    conv_cnt;
        logic                                 busy_seen;
        logic                                 three_lane;
        logic [BIT_CNT_W-1:0]                 bit_cnt;
        logic                                 sclk;
        logic                                 cs_n;
        logic                                 convst;
        logic                                 done;
        logic [N_WORDS-1:0][WORD_W-1:0]       res;
    } ctrl_t;

    ctrl_t d, q;

    logic                          phase_end;
    logic                          sample_en;
    logic                          word_end;
    logic [BIT_CNT_W-1:0]          frame_bits;
    logic [WIDX_W-1:0]             word_idx;
    logic [N_LANE-1:0][WORD_W-1:0] lane_word;
    logic [N_LANE-1:0][SLOT_W-1:0] lane_slot;
    logic [N_LANE-1:0]             lane_valid;

    assign phase_end  = (q.div == DIV_W'(HALF_DIV - 1));
    assign sample_en  = (q.state == ST_XFER) && q.sclk && phase_end;
    assign word_end   = sample_en && (q.bit_cnt[$clog2(WORD_W)-1:0] == '1);
    assign word_idx   = q.bit_cnt[BIT_CNT_W-1:$clog2(WORD_W)];
    assign frame_bits = q.three_lane ? BIT_CNT_W'(BITS_3L) : BIT_CNT_W'(BITS_2L);

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        rdo_lane_shift #(.W(WORD_W)) u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (sample_en),
            .din_i  (lane_din_i[l]),
            .word_o (lane_word[l])
        );
        rdo_slot_map #(.LANE(l)) u_map (
            .three_lane_i (q.three_lane),
            .word_idx_i   (word_idx),
            .slot_o       (lane_slot[l]),
            .valid_o      (lane_valid[l])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state      = ST_CONV;
                    d.convst     = 1'b1;
                    d.conv_cnt   = '0;
                    d.busy_seen  = 1'b0;
                    d.three_lane = lanes3_i;
                end
            end
            ST_CONV: begin
                if (busy_i) d.busy_seen = 1'b1;
                if (q.conv_cnt == CONV_W'(CONV_CYC - 1)) begin
                    d.convst = 1'b0;
                    d.state  = ST_WAIT;
                end else begin
                    d.conv_cnt = q.conv_cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (busy_i) begin
                    d.busy_seen = 1'b1;
                end else if (q.busy_seen) begin
                    d.state   = ST_XFER;
                    d.cs_n    = 1'b0;
                    d.sclk    = 1'b1;
                    d.div     = '0;
                    d.bit_cnt = '0;
                end
            end
            ST_XFER: begin
                if (phase_end) begin
                    d.div = '0;
                    if (q.sclk) begin
                        d.sclk    = 1'b0;
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        if (word_end) begin
                            for (int l = 0; l < N_LANE; l++) begin
                                if (lane_valid[l]) d.res[lane_slot[l]] = lane_word[l];
                            end
                        end
                    end else if (q.bit_cnt == frame_bits) begin
                        d.state = ST_DONE;
                        d.cs_n  = 1'b1;
                        d.sclk  = 1'b1;
                        d.done  = 1'b1;
                    end else begin
                        d.sclk = 1'b1;
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state      <= ST_IDLE;
            q.div        <= '0;
            q.conv_cnt   <= '0;
            q.busy_seen  <= 1'b0;
            q.three_lane <= 1'b0;
            q.bit_cnt    <= '0;
            q.sclk       <= 1'b1;
            q.cs_n       <= 1'b1;
            q.convst     <= 1'b0;
            q.done       <= 1'b0;
            q.res        <= '0;
        end else begin
            q <= d;
        end
    end

    assign convst_o = q.convst;
    assign cs_n_o   = q.cs_n;
    assign sclk_o   = q.sclk;
    assign done_o   = q.done;
    assign result_o = q.res;
endmodule

// File: rtl/rdo_checker.sv
module rdo_checker #(
    parameter int CONV_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic convst,
    input logic cs_n,
    input logic sclk,
    input logic done
);
    int hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_cnt_q <= 0;
        else if (convst) hi_cnt_q <= hi_cnt_q + 1;
        else             hi_cnt_q <= 0;
    end

    a_r2_conv_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
        convst |-> hi_cnt_q < CONV_CYC);

    a_r2_conv_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst) |-> hi_cnt_q == CONV_CYC);

    a_r2_conv_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !(convst && !cs_n));

    a_r3_frame_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!busy));

    a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    a_r11_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cs_n) |=> !convst);
endmodule

bind daisy_readout_ctrl rdo_checker #(.CONV_CYC(CONV_CYC)) u_rdo_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .busy   (busy_i),
    .convst (convst_o),
    .cs_n   (cs_n_o),
    .sclk   (sclk_o),
    .done   (done_o)
);

// File: tb/daisy_readout_ctrl_test.sv
`timescale 1ns/1ps
module daisy_readout_ctrl_test;
    localparam int HALF = 2;
    localparam int CONV = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         busy = 1'b0;
    logic         lanes3 = 1'b0;
    logic [2:0]   din = 3'b000;
    logic         convst, cs_n, sclk, done;
    logic [191:0] result;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    daisy_readout_ctrl #(.HALF_DIV(HALF), .CONV_CYC(CONV)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .busy_i     (busy),
        .lanes3_i   (lanes3),
        .lane_din_i (din),
        .convst_o   (convst),
        .cs_n_o     (cs_n),
        .sclk_o     (sclk),
        .result_o   (result),
        .done_o     (done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog (all reqs) act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    bit q0[$], q1[$], q2[$];

    function automatic bit popb(ref bit q[$]);
        if (q.size() == 0) return 1'b0;
        return q.pop_front();
    endfunction

    task automatic push_word(ref bit q[$], input logic [15:0] w);
        for (int b = 15; b >= 0; b--) q.push_back(w[b]);
    endtask

    task automatic drive_bits();
        logic [2:0] v;
        v[0] = popb(q0);
        v[1] = popb(q1);
        v[2] = popb(q2);
        din = v;
    endtask

    task automatic run_frame(input bit three, input int pat, input int busy_len);
        logic [15:0] val [12];
        int frame = three ? 64 : 96;
        int seen_busy = 0;
        int waited = 0;
        int ch2a [3] = '{0, 1, 4};
        int ch2b [3] = '{2, 3, 5};
        string rf = three ? "R6" : "R5";
        string rm = three ? "R8" : "R7";

        for (int i = 0; i < 12; i++) begin
            case (pat)
                0:       val[i] = 16'h1000 + 16'(i) * 16'h0111;
                1:       val[i] = (i % 2 == 1) ? 16'hFFFF : 16'h0000;
                2:       val[i] = 16'h8001 ^ 16'(i << 4);
                default: val[i] = 16'($urandom);
            endcase
        end
        q0.delete(); q1.delete(); q2.delete();
        for (int dv = 0; dv < 2; dv++) begin
            if (three) begin
                for (int k = 0; k < 2; k++) begin
                    push_word(q0, val[dv*6 + k]);
                    push_word(q1, val[dv*6 + 2 + k]);
                    push_word(q2, val[dv*6 + 4 + k]);
                end
            end else begin
                for (int k = 0; k < 3; k++) begin
                    push_word(q0, val[dv*6 + ch2a[k]]);
                    push_word(q1, val[dv*6 + ch2b[k]]);
                end
            end
        end
        if (!three) for (int i = 0; i < 96; i++) q2.push_back(1'($urandom));

        @(negedge clk);
        start  = 1'b1;
        lanes3 = three;
        @(negedge clk);
        start  = 1'b0;
        // conversion and wait phase, cycle c counted after the accepting edge
        for (int c = 0; cs_n && waited < 300; c++) begin
            if (c < CONV) chk(convst == 1'b1, "R2 convst high", convst, 1);
            else          chk(convst == 1'b0, "R2 convst low", convst, 0);
            if (c == 1) begin busy = 1'b1; seen_busy = 1; end
            if (c == 1 + busy_len) busy = 1'b0;
            if (c == 2) start = 1'b1;  // R11 request during conversion
            if (c == 3) start = 1'b0;
            waited++;
            @(negedge clk);
            if (!cs_n) chk(seen_busy == 1 && busy == 1'b0 && c >= busy_len, "R3 frame start",
                           {busy, 1'b0}, 0);
        end
        chk(cs_n == 1'b0, "R3 frame opened", cs_n, 0);
        drive_bits();  // R4 first bit present at chip-select fall
        for (int j = 0; j < 2*HALF*frame; j++) begin
            if (j > 0 && j % (2*HALF) == 0) drive_bits();
            if (j == 10) start = 1'b1;  // R11 request in mid-frame
            if (j == 11) start = 1'b0;
            chk(sclk == (((j / HALF) % 2) == 0), "R4 sclk phase", sclk, ((j / HALF) % 2) == 0);
            chk(cs_n == 1'b0 && convst == 1'b0 && done == 1'b0, {rf, " frame held"},
                {cs_n, convst, done}, 0);
            @(negedge clk);
        end
        chk(cs_n == 1'b1, {rf, " frame length"}, cs_n, 1);
        chk(done == 1'b1, "R10 done at close", done, 1);
        chk(sclk == 1'b1, "R4 sclk idle", sclk, 1);
        for (int i = 0; i < 12; i++)
            chk(result[i*16 +: 16] == val[i], {rm, "/R9 word"}, result[i*16 +: 16], val[i]);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single", done, 0);
        for (int i = 0; i < 10; i++) begin
            chk(convst == 1'b0 && cs_n == 1'b1, "R11 no restart", {convst, cs_n}, 1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(convst == 1'b0 && cs_n == 1'b1 && sclk == 1'b1 && done == 1'b0,
            "R1 in reset", {convst, cs_n, sclk, done}, 4'b0110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(convst == 1'b0 && cs_n == 1'b1 && sclk == 1'b1 && done == 1'b0,
            "R1 after reset", {convst, cs_n, sclk, done}, 4'b0110);
        chk(result == '0, "R1 results clear", result[63:0], 0);
        repeat (3) @(negedge clk);
        chk(convst == 1'b0 && cs_n == 1'b1, "R1 idle without start", {convst, cs_n}, 1);

        run_frame(1'b0, 0, 6);
        run_frame(1'b1, 0, 8);
        run_frame(1'b0, 1, 20);
        run_frame(1'b1, 2, 6);
        run_frame(1'b0, 3, 12);
        run_frame(1'b1, 3, 7);
        run_frame(1'b0, 2, 6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule